// File: doc/BRIEF.md
# Interrupt Line Aggregator

The aggregator merges per-device interrupt requests from five device-class interrupt lines, numbered 3 to 7, each serving up to eight devices numbered 0 to 7, together with a single timer request on line 2. For each device line it keeps a registered map of which devices are requesting service, after masking by a static map of which devices are fitted. It drives one interrupt output per line. A line output stays high for as long as any fitted device on that line holds its request. A device holds its request until software acknowledges it at the device.

Software reads both maps as 32-bit words over a simple combinational read port. A priority encoder names the most urgent source. Lower line numbers are more urgent, and within a line the lowest-numbered device wins. A separate decoder splits a CPU address in the device register area into its line number, device number and register word. Each device owns a 16-byte block, and each line owns a 128-byte slice of the area.

Top module: `irq_aggregator`

## Requirements
- R1: One clock edge after a fitted device raises its request, its bit (bit n for device n) reads 1 in its line's pending map, and the line output is 1. One edge after the request drops, the bit clears.
- R2: A request from a device whose fitted bit is 0 never sets a pending bit and never raises its line output.
- R3: A line output equals the OR of that line's pending bits. It stays 1 while any device on the line still requests, even after the others are acknowledged.
- R4: Bit 0 of `line_irq_o` (line 2) follows `timer_irq_i` one edge later. Bit k of `line_irq_o` is line k+2.
- R5: A read at `INST_BASE + 4*k` returns the fitted map of line k+3 in bits [7:0], with zeros above.
- R6: A read at `PEND_BASE + 4*k` returns the pending map of line k+3 in bits [7:0], with zeros above.
- R7: A read at any other address, including addresses that are not word-aligned or lie past the last line, returns 0.
- R8: When any line output is 1, `prio_valid_o` is 1. `prio_line_o` is then the lowest-numbered asserted line, and `prio_dev_o` is its lowest-numbered pending device (0 for the timer). With no line asserted, `prio_valid_o` is 0.
- R9: For `AREA_BASE <= a < AREA_BASE + 0x280`, the decoder reports hit=1 and splits the offset o = a - AREA_BASE as follows: line = 3 + o/0x80, device = o[6:4], register word = o[3:2].
- R10: Outside that range, the decoder reports hit=0 with line, device and register word all 0.
- R11: While reset is asserted and right after it is released, all pending maps and line outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timer_irq_i | input | 1 | Timer request (line 2) |
| dev_irq_i | input | 40 | Device requests, bit 8*k+n = line k+3, device n |
| dev_inst_i | input | 40 | Fitted straps, same bit layout |
| rd_addr_i | input | 32 | Map read address |
| rd_data_o | output | 32 | Map read data |
| dec_addr_i | input | 32 | Address to decode |
| dec_hit_o | output | 1 | Address lies in device area |
| dec_line_o | output | 3 | Decoded line number |
| dec_dev_o | output | 3 | Decoded device number |
| dec_reg_o | output | 2 | Decoded register word in the device block |
| line_irq_o | output | 6 | Line outputs, bit k = line k+2 |
| prio_valid_o | output | 1 | Some line is asserted |
| prio_line_o | output | 3 | Most urgent line number |
| prio_dev_o | output | 3 | Most urgent device on that line |

## Verification
On every cycle, the assertions tie each line output to the masked requests of the previous cycle, tie the timer line to its input, and check that no unfitted device is pending. They also check that the reported priority line is asserted, that no lower line is asserted, that the reported device is pending, and that decoded line numbers stay inside 3 to 7. Only the directed scenarios can show the exact word contents of the map reads, zero returns for unaligned and out-of-range addresses, and exact decode values at the area edges. The same holds for sequences in which devices on one line are acknowledged one at a time.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned DEVS_PER_LINE  = 8;
  localparam int unsigned FIRST_DEV_LINE = 3;
  localparam int unsigned TIMER_LINE     = 2;
  localparam int unsigned DEV_W          = $clog2(DEVS_PER_LINE);
  localparam int unsigned BLOCK_BYTES    = 16;
  localparam int unsigned SLICE_BYTES    = DEVS_PER_LINE * BLOCK_BYTES;
  typedef logic [2:0]       line_num_t;
  typedef logic [DEV_W-1:0] dev_num_t;
endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank
  import irqagg_pkg::*;
#(
  parameter int unsigned DEVS = DEVS_PER_LINE
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DEVS-1:0]         req_i,
  input  logic [DEVS-1:0]         inst_i,
  output logic [DEVS-1:0]         pend_o,
  output logic                    line_o,
  output logic [$clog2(DEVS)-1:0] dev_o
);
  localparam int unsigned DW = $clog2(DEVS);

  logic [DEVS-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= req_i & inst_i;
  end

  assign pend_o = pend_q;
  assign line_o = |pend_q;

  // lowest set index wins
  always_comb begin
    dev_o = '0;
    for (int i = DEVS - 1; i >= 0; i--) begin
      if (pend_q[i]) dev_o = DW'(i);
    end
  end

  AST_NO_UNINST_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(inst_i) |-> ((pend_q & ~inst_i) == '0)); // R2

  AST_DEV_IS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o |-> pend_q[dev_o]); // R8
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irqagg_pkg::*;
#(
  parameter int unsigned N  = 6,
  parameter int unsigned DW = DEV_W
) (
  input  logic [N-1:0]         lines_i,
  input  logic [N*DW-1:0]      devs_i,
  output logic                 valid_o,
  output logic [$clog2(N)-1:0] idx_o,
  output logic [DW-1:0]        dev_o
);
  localparam int unsigned IW = $clog2(N);

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    dev_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lines_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
        dev_o   = devs_i[i*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irqagg_pkg::*;
#(
  parameter logic [31:0] BASE      = 32'h1000_0050,
  parameter int unsigned NUM_LINES = 5
) (
  input  logic [31:0] addr_i,
  output logic        hit_o,
  output line_num_t   line_o,
  output dev_num_t    dev_o,
  output logic [1:0]  reg_o
);
  localparam logic [31:0] SPAN  = 32'(NUM_LINES * SLICE_BYTES);
  localparam int unsigned SL_SH = $clog2(SLICE_BYTES);
  localparam int unsigned BL_SH = $clog2(BLOCK_BYTES);

  logic [31:0] off;

  assign off   = addr_i - BASE;
  assign hit_o = (addr_i >= BASE) && (off < SPAN);

  always_comb begin
    line_o = '0;
    dev_o  = '0;
    reg_o  = '0;
    if (hit_o) begin
      line_o = line_num_t'(off >> SL_SH) + line_num_t'(FIRST_DEV_LINE);
      dev_o  = off[BL_SH +: DEV_W];
      reg_o  = off[3:2];
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_LINES = 5,
  parameter logic [31:0] AREA_BASE = 32'h1000_0050,
  parameter logic [31:0] INST_BASE = 32'h1000_0000,
  parameter logic [31:0] PEND_BASE = 32'h1000_0020
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               timer_irq_i,
  input  logic [NUM_LINES*DEVS_PER_LINE-1:0] dev_irq_i,
  input  logic [NUM_LINES*DEVS_PER_LINE-1:0] dev_inst_i,
  input  logic [31:0]                        rd_addr_i,
  output logic [31:0]                        rd_data_o,
  input  logic [31:0]                        dec_addr_i,
  output logic                               dec_hit_o,
  output logic [2:0]                         dec_line_o,
  output logic [2:0]                         dec_dev_o,
  output logic [1:0]                         dec_reg_o,
  output logic [NUM_LINES:0]                 line_irq_o,
  output logic                               prio_valid_o,
  output logic [2:0]                         prio_line_o,
  output logic [2:0]                         prio_dev_o
);
  localparam int unsigned D  = DEVS_PER_LINE;
  localparam int unsigned NL = NUM_LINES + 1;
  localparam int unsigned IW = $clog2(NL);

  logic                 timer_q;
  logic [NUM_LINES-1:0] bank_line;
  logic [NUM_LINES*D-1:0]     bank_pend;
  logic [NL*DEV_W-1:0]  all_devs;
  logic [IW-1:0]        pick_idx;
  dev_num_t             pick_dev;
  logic                 past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q   <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      timer_q   <= timer_irq_i;
      past_ok_q <= 1'b1;
    end
  end

  assign all_devs[DEV_W-1:0] = '0;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    irq_line_bank #(.DEVS(D)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (dev_irq_i[k*D +: D]),
      .inst_i (dev_inst_i[k*D +: D]),
      .pend_o (bank_pend[k*D +: D]),
      .line_o (bank_line[k]),
      .dev_o  (all_devs[(k+1)*DEV_W +: DEV_W])
    );

    AST_LINE_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok_q |-> (line_irq_o[k+1] ==
        |($past(dev_irq_i[k*D +: D]) & $past(dev_inst_i[k*D +: D])))); // R3
  end

  assign line_irq_o = {bank_line, timer_q};

  irq_prio_pick #(.N(NL), .DW(DEV_W)) u_pick (
    .lines_i (line_irq_o),
    .devs_i  (all_devs),
    .valid_o (prio_valid_o),
    .idx_o   (pick_idx),
    .dev_o   (pick_dev)
  );

  assign prio_line_o = 3'(pick_idx) + 3'(TIMER_LINE);
  assign prio_dev_o  = 3'(pick_dev);

  irq_addr_dec #(.BASE(AREA_BASE), .NUM_LINES(NUM_LINES)) u_dec (
    .addr_i (dec_addr_i),
    .hit_o  (dec_hit_o),
    .line_o (dec_line_o),
    .dev_o  (dec_dev_o),
    .reg_o  (dec_reg_o)
  );

  // map read port
  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_LINES; k++) begin
      if (rd_addr_i == INST_BASE + 32'(4 * k)) rd_data_o[D-1:0] = dev_inst_i[k*D +: D];
      if (rd_addr_i == PEND_BASE + 32'(4 * k)) rd_data_o[D-1:0] = bank_pend[k*D +: D];
    end
  end

  AST_TIMER_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> (line_irq_o[0] == $past(timer_irq_i))); // R4

  AST_PRIO_ASSERTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prio_valid_o |-> line_irq_o[prio_line_o - 3'(TIMER_LINE)]); // R8

  AST_PRIO_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prio_valid_o |-> ((line_irq_o & ((NL'(1) << (prio_line_o - 3'(TIMER_LINE))) - NL'(1))) == '0)); // R8

  AST_DEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_hit_o |-> (dec_line_o >= 3'(FIRST_DEV_LINE) &&
                   dec_line_o <= 3'(FIRST_DEV_LINE + NUM_LINES - 1))); // R9

  AST_DEC_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_hit_o |-> (dec_line_o == '0 && dec_dev_o == '0 && dec_reg_o == '0)); // R10
endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  localparam logic [31:0] AREA = 32'h1000_0050;
  localparam logic [31:0] INSB = 32'h1000_0000;
  localparam logic [31:0] PNDB = 32'h1000_0020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        timer = 1'b0;
  logic [39:0] irq = '0;
  logic [39:0] inst;
  logic [31:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] dec_addr = '0;
  logic        dec_hit;
  logic [2:0]  dec_line, dec_dev, prio_line, prio_dev;
  logic [1:0]  dec_reg;
  logic [5:0]  line_irq;
  logic        prio_valid;
  int          total = 0;
  int          fails = 0;

  // fitted: line3 FF, line4 0F, line5 A5, line6 00, line7 81
  assign inst = {8'h81, 8'h00, 8'hA5, 8'h0F, 8'hFF};

  always #2 clk = ~clk;

  irq_aggregator uut (
    .clk_i(clk), .rst_ni(rst_n), .timer_irq_i(timer),
    .dev_irq_i(irq), .dev_inst_i(inst),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .dec_addr_i(dec_addr), .dec_hit_o(dec_hit), .dec_line_o(dec_line),
    .dec_dev_o(dec_dev), .dec_reg_o(dec_reg),
    .line_irq_o(line_irq), .prio_valid_o(prio_valid),
    .prio_line_o(prio_line), .prio_dev_o(prio_dev)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd_pend(input int k, input string req, input logic [7:0] exp);
    rd_addr = PNDB + 32'(4 * k);
    #1;
    check(req, rd_data, {24'h0, exp});
  endtask

  task automatic set_req(input int line, input int dev, input logic v);
    irq[(line - 3) * 8 + dev] = v;
  endtask

  task automatic t_reset();
    irq = '1;
    timer = 1'b1;
    tick();
    check("R11 line outputs in reset", 32'(line_irq), 0);
    rd_pend(2, "R11 pend map in reset", 8'h00);
    irq = '0;
    timer = 1'b0;
    rst_n = 1'b1;
    tick();
    check("R11 line outputs after reset", 32'(line_irq), 0);
    check("R11 prio_valid after reset", 32'(prio_valid), 0);
  endtask

  task automatic t_single();
    set_req(4, 2, 1'b1);
    tick();
    check("R1 line4 output", 32'(line_irq[2]), 1);
    rd_pend(1, "R1/R6 line4 pend map", 8'h04);
    check("R8 prio line", 32'(prio_line), 4);
    check("R8 prio dev", 32'(prio_dev), 2);
    set_req(4, 2, 1'b0);
    tick();
    check("R1 line4 cleared", 32'(line_irq), 0);
    rd_pend(1, "R1 line4 pend cleared", 8'h00);
  endtask

  task automatic t_uninst();
    set_req(4, 6, 1'b1);
    irq[31:24] = 8'hFF;
    tick();
    tick();
    check("R2 no line output", 32'(line_irq), 0);
    rd_pend(1, "R2 line4 pend", 8'h00);
    rd_pend(3, "R2 line6 pend", 8'h00);
    check("R2 prio_valid", 32'(prio_valid), 0);
    irq = '0;
    tick();
  endtask

  task automatic t_multi_ack();
    irq[23:16] = 8'h85;
    tick();
    rd_pend(2, "R6 line5 pend", 8'h85);
    check("R3 line5 set", 32'(line_irq[3]), 1);
    set_req(5, 0, 1'b0);
    tick();
    check("R3 line5 held after dev0 ack", 32'(line_irq[3]), 1);
    rd_pend(2, "R3 line5 pend", 8'h84);
    set_req(5, 2, 1'b0);
    tick();
    check("R3 line5 held after dev2 ack", 32'(line_irq[3]), 1);
    set_req(5, 7, 1'b0);
    tick();
    check("R3 line5 drops after last ack", 32'(line_irq[3]), 0);
  endtask

  task automatic t_timer();
    timer = 1'b1;
    set_req(3, 1, 1'b1);
    tick();
    check("R4 timer line bit0", 32'(line_irq[0]), 1);
    check("R4 line3 bit1", 32'(line_irq[1]), 1);
    check("R8 timer beats line3", 32'(prio_line), 2);
    check("R8 timer dev", 32'(prio_dev), 0);
    timer = 1'b0;
    tick();
    check("R4 timer cleared", 32'(line_irq[0]), 0);
    check("R8 line3 now", {prio_line, prio_dev}, {3'd3, 3'd1});
    irq = '0;
    tick();
  endtask

  task automatic t_priority();
    set_req(7, 7, 1'b1);
    set_req(5, 5, 1'b1);
    tick();
    check("R8 line5 over line7", {prio_valid, prio_line, prio_dev}, {1'b1, 3'd5, 3'd5});
    set_req(5, 2, 1'b1);
    tick();
    check("R8 lowest device", {prio_line, prio_dev}, {3'd5, 3'd2});
    irq[23:16] = 8'h00;
    tick();
    check("R8 falls to line7", {prio_line, prio_dev}, {3'd7, 3'd7});
    irq = '0;
    tick();
    check("R8 none", 32'(prio_valid), 0);
  endtask

  task automatic t_reads();
    for (int k = 0; k < 5; k++) begin
      rd_addr = INSB + 32'(4 * k);
      #1;
      check($sformatf("R5 fitted map line %0d", k + 3), rd_data, {24'h0, inst[k*8 +: 8]});
    end
    rd_addr = INSB + 32'h2;  #1; check("R7 unaligned", rd_data, 0);
    rd_addr = INSB + 32'h14; #1; check("R7 past fitted maps", rd_data, 0);
    rd_addr = PNDB + 32'h14; #1; check("R7 past pend maps", rd_data, 0);
    rd_addr = 32'h0;         #1; check("R7 zero addr", rd_data, 0);
  endtask

  task automatic t_decode();
    dec_addr = AREA; #1;
    check("R9 first block", {dec_hit, dec_line, dec_dev, dec_reg}, {1'b1, 3'd3, 3'd0, 2'd0});
    dec_addr = AREA + 32'h158; #1;
    check("R9 mid block", {dec_hit, dec_line, dec_dev, dec_reg}, {1'b1, 3'd5, 3'd5, 2'd2});
    dec_addr = AREA + 32'h27C; #1;
    check("R9 last word", {dec_hit, dec_line, dec_dev, dec_reg}, {1'b1, 3'd7, 3'd7, 2'd3});
    dec_addr = AREA + 32'h280; #1;
    check("R10 past end", {dec_hit, dec_line, dec_dev, dec_reg}, 0);
    dec_addr = AREA - 32'h4; #1;
    check("R10 below base", {dec_hit, dec_line, dec_dev, dec_reg}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_single();
    t_uninst();
    t_multi_ack();
    t_timer();
    t_priority();
    t_reads();
    t_decode();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule